// File: doc/BRIEF.md
# Range-Based Access Protection Checker

This block guards the configuration port of a peripheral. It holds a small table of programmable address ranges. Each range has an inclusive lower and upper bound with 1 KB granularity, and a 32-bit permission word. For every request presented on the request inputs, the block gives a combinational allow or deny verdict. It bases the verdict on the address, the 4-bit privilege ID, the privilege mode (user or supervisor) and the access kind (read, write or execute).

The policy is permissive by default. An address that no range covers passes. A range whose allow bit for the requester's ID is clear also leaves the request alone. When several ranges cover the address, each range that restricts the requester must grant the access, so their rights intersect.

A denied request that is marked valid is logged. The first such fault latches the address, ID, mode and kind, and raises a level fault interrupt. Later faults only set an overflow flag. Software writes the value zero to the end-of-interrupt port to drop the interrupt and clear the log.

Top module: `range_guard`

## Requirements
- R1: A request whose address lies in no configured range is allowed (`req_allow`=1).
- R2: A range whose permission bit 10+`req_pid` is 0 places no restriction on that request, whatever its mode bits hold.
- R3: A permission word of 0 allows every access to its range. The word 0x03FFFC00 (all 16 ID bits 25:10 set, all mode bits clear) denies reads, writes and executes for every ID and mode.
- R4: In a restricting range, the grant comes from the mode bits. Bits 2/1/0 are user read/write/execute, and bits 5/4/3 are supervisor read/write/execute. Access kind 0 is read, 1 is write, 2 is execute, and kind 3 is never granted.
- R5: When ranges overlap, the request is allowed only if every restricting range grants it. A supervisor read/write range overlapping a supervisor read/execute range yields read-only.
- R6: A range covers addresses from (lower bound & ~0x3FF) through (upper bound | 0x3FF), with both ends inclusive.
- R7: A valid denied request sets `fault_irq` from the next cycle on. The interrupt stays high until the end-of-interrupt port is written with 0. A write of any nonzero value has no effect.
- R8: The first fault after a clear captures address, ID, mode and kind into the `flt_*` outputs. Later faults leave the capture unchanged and set `flt_overflow`.
- R9: An end-of-interrupt write of 0 clears `fault_irq`, `flt_valid` and `flt_overflow` at the next edge. A fault in that same cycle is then captured as a fresh first fault, without overflow.
- R10: After reset, all ranges have permission 0, so every access is allowed, and no fault is pending. A denied request with `req_valid`=0 still shows `req_allow`=0 but logs nothing.
- R11: Configuration writes take effect at the next edge. `cfg_sel` 0 writes the lower bound, 1 writes the upper bound and 2 writes the permission word of range `cfg_idx`. `cfg_sel` 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Range selected for the write |
| cfg_sel | input | 2 | Field selector: 0 lower, 1 upper, 2 permission |
| cfg_wdata | input | 32 | Configuration write data |
| eoi_we | input | 1 | End-of-interrupt write strobe |
| eoi_data | input | 32 | End-of-interrupt value; 0 clears |
| req_valid | input | 1 | Request present, eligible for fault logging |
| req_addr | input | 32 | Request address |
| req_pid | input | 4 | Requester privilege ID |
| req_super | input | 1 | 1 for supervisor, 0 for user |
| req_type | input | 2 | 0 read, 1 write, 2 execute |
| req_allow | output | 1 | Combinational verdict |
| fault_irq | output | 1 | Level fault interrupt |
| flt_valid | output | 1 | Capture holds a fault |
| flt_overflow | output | 1 | More faults arrived after the capture |
| flt_addr | output | 32 | Captured address |
| flt_pid | output | 4 | Captured privilege ID |
| flt_super | output | 1 | Captured mode |
| flt_type | output | 2 | Captured access kind |

## Verification
The assertions assume that the request inputs are stable between edges. They also assume that an end-of-interrupt write lasts a single cycle, so a clear and a following fault are seen at separate edges unless they are driven together on purpose. The stimulus changes inputs only on the falling clock edge. It holds each strobe for exactly one cycle, and it drives a fault and a zero end-of-interrupt together in one deliberate case. The requests use access kinds 0 to 2 only. Programmed bounds always keep the lower bound at or below the upper bound.

// File: rtl/rg_pkg.sv
package rg_pkg;
    localparam int CFG_W       = 32;
    localparam int ID_FIELD_LO = 10;
    localparam int ID_COUNT    = 16;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_NONE  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FLD_LOWER = 2'd0,
        FLD_UPPER = 2'd1,
        FLD_PERM  = 2'd2,
        FLD_NONE  = 2'd3
    } fld_e;
endpackage

// File: rtl/rg_range_cell.sv
module rg_range_cell
    import rg_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int BLK_LSB = 10,
    parameter int PID_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_fld,
    input  logic [CFG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [PID_W-1:0]  chk_pid,
    input  logic              chk_super,
    input  logic [1:0]        chk_kind,
    output logic              hit_o,
    output logic              veto_o
);
    localparam int BW = ADDR_W - BLK_LSB;

    typedef struct packed {
        logic [BW-1:0]    lower;
        logic [BW-1:0]    upper;
        logic [CFG_W-1:0] perm;
    } cell_t;

    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (wr_en) begin
            case (fld_e'(wr_fld))
                FLD_LOWER: cell_d.lower = wr_data[ADDR_W-1:BLK_LSB];
                FLD_UPPER: cell_d.upper = wr_data[ADDR_W-1:BLK_LSB];
                FLD_PERM:  cell_d.perm  = wr_data;
                default:   cell_d = cell_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cell_q <= '0;
        else        cell_q <= cell_d;
    end

    logic [BW-1:0]       blk;
    logic [ID_COUNT-1:0] id_mask;
    logic [2:0]          rwx;
    logic                id_on;
    logic                grant;

    always_comb begin
        blk     = chk_addr[ADDR_W-1:BLK_LSB];
        id_mask = cell_q.perm[ID_FIELD_LO +: ID_COUNT];
        id_on   = id_mask[chk_pid];
        rwx     = chk_super ? cell_q.perm[5:3] : cell_q.perm[2:0];
        case (acc_e'(chk_kind))
            ACC_READ:  grant = rwx[2];
            ACC_WRITE: grant = rwx[1];
            ACC_EXEC:  grant = rwx[0];
            default:   grant = 1'b0;
        endcase
        hit_o  = (blk >= cell_q.lower) && (blk <= cell_q.upper);
        veto_o = hit_o && id_on && !grant;
    end

    // R11: a permission write lands at the next edge
    a_r11_perm_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_fld == FLD_PERM) |=> (cell_q.perm == $past(wr_data)));

    // R3: an all-zero permission word never vetoes
    a_r3_zero_perm: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_q.perm == '0) |-> !veto_o);
endmodule

// File: rtl/rg_fault_log.sv
module rg_fault_log #(
    parameter int ADDR_W = 32,
    parameter int PID_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_i,
    input  logic              clear_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [PID_W-1:0]  pid_i,
    input  logic              super_i,
    input  logic [1:0]        kind_i,
    output logic              valid_o,
    output logic              ovf_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [PID_W-1:0]  pid_o,
    output logic              super_o,
    output logic [1:0]        kind_o
);
    typedef struct packed {
        logic              valid;
        logic              ovf;
        logic [ADDR_W-1:0] addr;
        logic [PID_W-1:0]  pid;
        logic              sup;
        logic [1:0]        kind;
    } log_t;

    log_t log_d, log_q;

    always_comb begin
        log_d = log_q;
        if (clear_i) begin
            log_d.valid = 1'b0;
            log_d.ovf   = 1'b0;
        end
        if (fault_i) begin
            if (!log_d.valid) begin
                log_d.valid = 1'b1;
                log_d.addr  = addr_i;
                log_d.pid   = pid_i;
                log_d.sup   = super_i;
                log_d.kind  = kind_i;
            end else begin
                log_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) log_q <= '0;
        else        log_q <= log_d;
    end

    assign valid_o = log_q.valid;
    assign ovf_o   = log_q.ovf;
    assign addr_o  = log_q.addr;
    assign pid_o   = log_q.pid;
    assign super_o = log_q.sup;
    assign kind_o  = log_q.kind;

    // R7: a pending fault persists until cleared
    a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (log_q.valid && !clear_i) |=> log_q.valid);

    // R8: later faults do not overwrite the capture
    a_r8_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (log_q.valid && !clear_i) |=> ($stable(log_q.addr) && $stable(log_q.pid)));

    // R8: overflow only follows an existing capture
    a_r8_ovf_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(log_q.ovf) |-> $past(log_q.valid));

    // R9: a clear with no new fault empties the log
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !fault_i) |=> (!log_q.valid && !log_q.ovf));
endmodule

// File: rtl/range_guard.sv
module range_guard
    import rg_pkg::*;
#(
    parameter int NUM_RANGES = 4,
    parameter int ADDR_W     = 32,
    parameter int BLK_LSB    = 10,
    parameter int PID_W      = 4,
    localparam int IDX_W     = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              eoi_we,
    input  logic [CFG_W-1:0]  eoi_data,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [PID_W-1:0]  req_pid,
    input  logic              req_super,
    input  logic [1:0]        req_type,
    output logic              req_allow,
    output logic              fault_irq,
    output logic              flt_valid,
    output logic              flt_overflow,
    output logic [ADDR_W-1:0] flt_addr,
    output logic [PID_W-1:0]  flt_pid,
    output logic              flt_super,
    output logic [1:0]        flt_type
);
    logic [NUM_RANGES-1:0] hit_vec;
    logic [NUM_RANGES-1:0] veto_vec;

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_cell
        rg_range_cell #(
            .ADDR_W (ADDR_W),
            .BLK_LSB(BLK_LSB),
            .PID_W  (PID_W)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (cfg_we && (cfg_idx == IDX_W'(g))),
            .wr_fld   (cfg_sel),
            .wr_data  (cfg_wdata),
            .chk_addr (req_addr),
            .chk_pid  (req_pid),
            .chk_super(req_super),
            .chk_kind (req_type),
            .hit_o    (hit_vec[g]),
            .veto_o   (veto_vec[g])
        );
    end

    logic fault_now;
    logic clear_now;

    always_comb begin
        req_allow = ~|veto_vec;
        fault_now = req_valid && !req_allow;
        clear_now = eoi_we && (eoi_data == '0);
    end

    rg_fault_log #(
        .ADDR_W(ADDR_W),
        .PID_W (PID_W)
    ) u_log (
        .clk    (clk),
        .rst_n  (rst_n),
        .fault_i(fault_now),
        .clear_i(clear_now),
        .addr_i (req_addr),
        .pid_i  (req_pid),
        .super_i(req_super),
        .kind_i (req_type),
        .valid_o(flt_valid),
        .ovf_o  (flt_overflow),
        .addr_o (flt_addr),
        .pid_o  (flt_pid),
        .super_o(flt_super),
        .kind_o (flt_type)
    );

    assign fault_irq = flt_valid;

    // R1: no covering range means the request passes
    a_r1_outside_allows: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec == '0) |-> req_allow);

    // R7: a valid denied request raises the interrupt next cycle
    a_r7_deny_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_allow) |=> fault_irq);

    // R10: no fault is logged without a valid request
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && !flt_valid) |=> !flt_valid);
endmodule

// File: tb/range_guard_tb.sv
module range_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        eoi_we = 1'b0;
    logic [31:0] eoi_data = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_pid = '0;
    logic        req_super = 1'b0;
    logic [1:0]  req_type = '0;
    logic        req_allow, fault_irq, flt_valid, flt_overflow, flt_super;
    logic [31:0] flt_addr;
    logic [3:0]  flt_pid;
    logic [1:0]  flt_type;

    int    total = 0;
    int    bad = 0;
    string cur_req = "R10";

    always #10 clk = ~clk;

    range_guard u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .eoi_we(eoi_we),
        .eoi_data(eoi_data), .req_valid(req_valid), .req_addr(req_addr),
        .req_pid(req_pid), .req_super(req_super), .req_type(req_type),
        .req_allow(req_allow), .fault_irq(fault_irq), .flt_valid(flt_valid),
        .flt_overflow(flt_overflow), .flt_addr(flt_addr), .flt_pid(flt_pid),
        .flt_super(flt_super), .flt_type(flt_type)
    );

    // reference model state
    logic [31:0] m_lo [4];
    logic [31:0] m_hi [4];
    logic [31:0] m_perm [4];
    bit          m_v, m_ov, m_sup;
    logic [31:0] m_addr;
    logic [3:0]  m_pid;
    logic [1:0]  m_kind;

    function automatic bit m_allow(logic [31:0] a, logic [3:0] pid, bit sup, logic [1:0] t);
        for (int i = 0; i < 4; i++) begin
            if ((a >> 10) >= (m_lo[i] >> 10) && (a >> 10) <= (m_hi[i] >> 10)
                && m_perm[i][10 + pid]) begin
                int b;
                b = (sup ? 3 : 0) + ((t == 2'd0) ? 2 : (t == 2'd1) ? 1 : 0);
                if (t == 2'd3 || !m_perm[i][b]) return 1'b0;
            end
        end
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_lo[i] = '0; m_hi[i] = '0; m_perm[i] = '0;
            end
            m_v = 0; m_ov = 0; m_addr = '0; m_pid = '0; m_sup = 0; m_kind = '0;
        end else begin
            bit f;
            f = req_valid && !m_allow(req_addr, req_pid, req_super, req_type);
            if (eoi_we && eoi_data == 32'd0) begin m_v = 0; m_ov = 0; end
            if (f) begin
                if (!m_v) begin
                    m_v = 1; m_addr = req_addr; m_pid = req_pid;
                    m_sup = req_super; m_kind = req_type;
                end else m_ov = 1;
            end
            if (cfg_we) begin
                case (cfg_sel)
                    2'd0: m_lo[cfg_idx] = cfg_wdata;
                    2'd1: m_hi[cfg_idx] = cfg_wdata;
                    2'd2: m_perm[cfg_idx] = cfg_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("req_allow", 32'(req_allow), 32'(m_allow(req_addr, req_pid, req_super, req_type)));
        chk("fault_irq", 32'(fault_irq), 32'(m_v));
        chk("flt_valid", 32'(flt_valid), 32'(m_v));
        chk("flt_overflow", 32'(flt_overflow), 32'(m_ov));
        if (m_v) begin
            chk("flt_addr", flt_addr, m_addr);
            chk("flt_pid", 32'(flt_pid), 32'(m_pid));
            chk("flt_super", 32'(flt_super), 32'(m_sup));
            chk("flt_type", 32'(flt_type), 32'(m_kind));
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic cfg(int idx, int sel, logic [31:0] d);
        cfg_we = 1; cfg_idx = 2'(idx); cfg_sel = 2'(sel); cfg_wdata = d;
        tick();
        cfg_we = 0;
    endtask

    task automatic acc(logic [31:0] a, int pid, bit sup, int t, bit v = 1'b1);
        req_valid = v; req_addr = a; req_pid = 4'(pid); req_super = sup; req_type = 2'(t);
        tick();
        req_valid = 0;
    endtask

    task automatic eoi(logic [31:0] d);
        eoi_we = 1; eoi_data = d;
        tick();
        eoi_we = 0;
    endtask

    initial begin
        #(20 * 200000);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R10 reset state
        repeat (3) @(negedge clk);
        compare();
        rst_n = 1;
        cur_req = "R10";
        acc(32'h0000_1400, 3, 0, 1);
        acc(32'hFFFF_FC00, 15, 1, 2);

        // R11 programming of range 0: 0x1000..0x1FFF, ID 3 supervisor read only
        cur_req = "R11";
        cfg(0, 0, 32'h0000_1000);
        cfg(0, 1, 32'h0000_1C00);
        cfg(0, 2, 32'h0000_2000 | 32'h20);
        cfg(0, 3, 32'hFFFF_FFFF);
        acc(32'h0000_1800, 3, 1, 0);

        // R1 outside address passes
        cur_req = "R1";
        acc(32'h0000_4000, 3, 0, 1);
        acc(32'h0000_0C00, 3, 1, 2);

        // R2 other ID unrestricted
        cur_req = "R2";
        acc(32'h0000_1200, 5, 0, 1);
        acc(32'h0000_1200, 2, 0, 2);

        // R4 mode bits for ID 3 (also first fault, R8)
        cur_req = "R4";
        acc(32'h0000_1200, 3, 1, 0);
        acc(32'h0000_1204, 3, 1, 1);
        acc(32'h0000_1208, 3, 0, 0);
        acc(32'h0000_1208, 3, 1, 3, 1'b0);

        // R7 nonzero EOI ignored, zero clears
        cur_req = "R7";
        eoi(32'h0000_0001);
        acc(32'h0000_4000, 0, 0, 0);
        cur_req = "R9";
        eoi(32'h0);
        acc(32'h0000_4000, 0, 0, 0);

        // R6 inclusive 1 KB bounds
        cur_req = "R6";
        acc(32'h0000_0FFF, 3, 0, 1);
        acc(32'h0000_1000, 3, 0, 1);
        eoi(32'h0);
        acc(32'h0000_1FFF, 3, 0, 2);
        eoi(32'h0);
        acc(32'h0000_2000, 3, 0, 1);

        // R3 deny-all and zero words on range 1
        cur_req = "R3";
        cfg(1, 0, 32'h0000_8000);
        cfg(1, 1, 32'h0000_8FFF);
        cfg(1, 2, 32'h03FF_FC00);
        for (int p = 0; p < 16; p += 5) begin
            acc(32'h0000_8100, p, 1, 0, 1'b0);
            acc(32'h0000_8FFC, p, 0, 1, 1'b0);
            acc(32'h0000_8000, p, 1, 2, 1'b0);
        end
        cfg(1, 2, 32'h0);
        acc(32'h0000_8100, 7, 1, 1);

        // R5 overlap intersection: RW range 2 and RX range 3
        cur_req = "R5";
        cfg(2, 0, 32'h0001_0000);
        cfg(2, 1, 32'h0001_3FFF);
        cfg(2, 2, 32'h03FF_FC00 | 32'h30);
        cfg(3, 0, 32'h0001_2000);
        cfg(3, 1, 32'h0001_7FFF);
        cfg(3, 2, 32'h03FF_FC00 | 32'h28);
        acc(32'h0001_2400, 9, 1, 0);
        acc(32'h0001_0400, 9, 1, 1);
        acc(32'h0001_6000, 9, 1, 2);

        // R8 first fault kept, later ones overflow
        cur_req = "R8";
        eoi(32'h0);
        acc(32'h0001_2400, 9, 1, 1);
        acc(32'h0001_2800, 4, 1, 2);
        acc(32'h0001_2C00, 6, 0, 0);

        // R10 invalid request is not logged
        cur_req = "R10";
        eoi(32'h0);
        acc(32'h0001_2400, 9, 1, 1, 1'b0);

        // R9 clear and fault in the same cycle
        cur_req = "R9";
        acc(32'h0001_2400, 1, 1, 1);
        acc(32'h0001_2400, 2, 1, 1);
        eoi_we = 1; eoi_data = 32'h0;
        req_valid = 1; req_addr = 32'h0001_3000; req_pid = 4'd12; req_super = 0; req_type = 2'd2;
        tick();
        eoi_we = 0; req_valid = 0;
        tick();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule